// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block sits between six core control pins and the core's exception logic. Pin activity reaches it as events. Each event carries a pin index and the pin's new level. The block keeps a registered copy of the last accepted level for every pin, and it acts only when an event brings a level different from that copy. Each accepted change is turned into core-side state according to the pin's own sensitivity:

- Two pins act as level-sensitive interrupt lines.
- One pin is a falling-edge, sticky error line.
- One pin is a run/stop control.
- One pin is a mirrored reset request.
- One pin is a reset stub that emits a single pulse.

The core sees a four-bit pending vector, an aggregate interrupt request and a halt flag, all registered. It retires the sticky error bit through a clear mask. Synchronisation of the raw pins, exception priority and the actual reset sequencing are handled elsewhere.

Pin indices are:

| Index | Pin |
|---|---|
| 0 | external interrupt |
| 1 | management interrupt |
| 2 | machine check |
| 3 | checkstop |
| 4 | hard reset |
| 5 | soft reset |

Indices 6 and 7 are unused. Pending vector bits are:

| Bit | Meaning |
|---|---|
| 0 | external |
| 1 | management |
| 2 | machine check |
| 3 | soft reset |

Every output changes at the first rising clock edge that samples the causing event or clear.

Top module: `irq_pin_cond`

## Requirements
- R1: An event whose level equals the stored level for its pin changes no output and no stored state.
- R2: Pending bit 0 follows accepted changes on pin 0, and pending bit 1 follows accepted changes on pin 1. Each bit is set by a change to 1 and cleared by a change to 0.
- R3: An accepted 1-to-0 change on pin 2 sets pending bit 2. An accepted 0-to-1 change on pin 2 leaves pending bit 2 unchanged.
- R4: Pending bit 2 stays set until a cycle with `clr_mask[2]` high. If a falling change on pin 2 arrives in that same cycle, the bit stays set.
- R5: `halt` goes high on an accepted change of pin 3 to 1, and goes low on an accepted change of pin 3 to 0.
- R6: Pending bit 3 mirrors the accepted level of pin 5.
- R7: `irq_req` is high exactly when the pending vector is non-zero.
- R8: Events with index 6 or 7 are ignored and leave the stored pin levels untouched.
- R9: After each accepted change, `pin_state[i]` holds the new level of pin i.
- R10: Reset clears the pending vector, `irq_req`, `halt`, `hreset_pulse` and all stored pin levels.
- R11: An accepted 0-to-1 change on pin 4 produces `hreset_pulse` high for exactly one cycle. A 1-to-0 change produces no pulse.
- R12: `clr_mask` bits 0, 1 and 3 have no effect on the pending vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | A pin event is presented this cycle |
| ev_idx | input | IDX_W | Pin index of the event |
| ev_level | input | 1 | New level of that pin |
| clr_mask | input | 4 | Clear request per pending bit (only bit 2 acts) |
| pend_vec | output | 4 | Pending request vector |
| irq_req | output | 1 | Aggregate interrupt request |
| halt | output | 1 | Core halt request |
| hreset_pulse | output | 1 | One-cycle hard-reset stub pulse |
| pin_state | output | 6 | Stored accepted level of each pin |

## Verification
The checker holds several properties on every cycle:

- The aggregate request always agrees with the pending vector.
- The level-following and mirrored bits always equal their stored pin levels.
- The error bit never rises without a falling event on its pin.
- Unknown indices never disturb the stored levels.
- `halt` only rises after a checkstop-high event.
- The reset stub pulse never lasts more than one cycle.

Other behaviours can only be shown by the bench's scenarios, which replay event streams against an independent model:

- Redundant same-level events are silent.
- The sticky error bit is retired by a clear.
- A clear coinciding with a new falling edge loses to that edge.
- Clears on non-sticky bits are ignored.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_PINS = 6;
  localparam int PEND_W   = 4;

  // pin indices
  localparam int PIN_EXT   = 0;
  localparam int PIN_SMI   = 1;
  localparam int PIN_MCK   = 2;
  localparam int PIN_STOP  = 3;
  localparam int PIN_HRST  = 4;
  localparam int PIN_SRST  = 5;

  // pending vector bit positions
  localparam int PB_EXT = 0;
  localparam int PB_SMI = 1;
  localparam int PB_MCK = 2;
  localparam int PB_RST = 3;

  typedef logic [NUM_PINS-1:0] pin_vec_t;
  typedef logic [PEND_W-1:0]   pend_vec_t;
endpackage

// File: rtl/irqc_change_det.sv
module irqc_change_det
  import irqc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  logic [IDX_W-1:0] ev_idx,
  input  logic             ev_level,
  output pin_vec_t         chg,
  output pin_vec_t         state_q
);
  // one change detector and stored level per known pin
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign chg[i] = ev_valid && (ev_idx == IDX_W'(i)) && (ev_level != state_q[i]);

    always_ff @(posedge clk) begin
      if (rst)         state_q[i] <= 1'b0;
      else if (chg[i]) state_q[i] <= ev_level;
    end
  end
endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
  import irqc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pin_vec_t  chg,
  input  logic      ev_level,
  input  pend_vec_t clr_mask,
  output pend_vec_t pend_q,
  output logic      irq_q
);
  pend_vec_t pend_d;

  always_comb begin
    pend_d = pend_q;
    if (chg[PIN_EXT])  pend_d[PB_EXT] = ev_level;
    if (chg[PIN_SMI])  pend_d[PB_SMI] = ev_level;
    if (chg[PIN_SRST]) pend_d[PB_RST] = ev_level;
    // sticky: a new falling edge wins over a clear in the same cycle
    if (chg[PIN_MCK] && !ev_level)  pend_d[PB_MCK] = 1'b1;
    else if (clr_mask[PB_MCK])      pend_d[PB_MCK] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= |pend_d;
    end
  end
endmodule

// File: rtl/irqc_run_ctl.sv
module irqc_run_ctl
  import irqc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  pin_vec_t chg,
  input  logic     ev_level,
  output logic     halt_q,
  output logic     hrst_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q <= 1'b0;
      hrst_q <= 1'b0;
    end else begin
      if (chg[PIN_STOP]) halt_q <= ev_level;
      hrst_q <= chg[PIN_HRST] && ev_level;
    end
  end
endmodule

// File: rtl/irq_pin_cond.sv
module irq_pin_cond
  import irqc_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_valid,
  input  logic [IDX_W-1:0] ev_idx,
  input  logic             ev_level,
  input  logic [3:0]       clr_mask,
  output logic [3:0]       pend_vec,
  output logic             irq_req,
  output logic             halt,
  output logic             hreset_pulse,
  output logic [5:0]       pin_state
);
  pin_vec_t chg;

  irqc_change_det #(.IDX_W(IDX_W)) u_det (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_idx(ev_idx),
    .ev_level(ev_level), .chg(chg), .state_q(pin_state)
  );

  irqc_pending u_pend (
    .clk(clk), .rst(rst), .chg(chg), .ev_level(ev_level),
    .clr_mask(clr_mask), .pend_q(pend_vec), .irq_q(irq_req)
  );

  irqc_run_ctl u_run (
    .clk(clk), .rst(rst), .chg(chg), .ev_level(ev_level),
    .halt_q(halt), .hrst_q(hreset_pulse)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ev_valid,
  input logic [IDX_W-1:0] ev_idx,
  input logic             ev_level,
  input logic [3:0]       clr_mask,
  input logic [3:0]       pend_vec,
  input logic             irq_req,
  input logic             halt,
  input logic             hreset_pulse,
  input logic [5:0]       pin_state
);
  // R7
  irq_matches_pend_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req == (pend_vec != 4'd0));

  // R2
  ext_follows_pin_chk: assert property (@(posedge clk) disable iff (rst)
    pend_vec[0] == pin_state[0] && pend_vec[1] == pin_state[1]);

  // R6
  srst_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    pend_vec[3] == pin_state[5]);

  // R3
  mck_no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!pend_vec[2] && !(ev_valid && ev_idx == IDX_W'(2) && !ev_level)) |=> !pend_vec[2]);

  // R8
  unknown_idx_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_idx >= IDX_W'(6)) |=> $stable(pin_state));

  // R5
  halt_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(halt) |-> $past(ev_valid && ev_idx == IDX_W'(3) && ev_level));

  // R11
  hreset_single_chk: assert property (@(posedge clk) disable iff (rst)
    hreset_pulse |=> !hreset_pulse);

  // R12
  clr_ext_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    !(ev_valid && ev_idx == IDX_W'(0)) |=> $stable(pend_vec[0]));
endmodule

bind irq_pin_cond irqc_checker #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_idx(ev_idx),
  .ev_level(ev_level), .clr_mask(clr_mask), .pend_vec(pend_vec),
  .irq_req(irq_req), .halt(halt), .hreset_pulse(hreset_pulse),
  .pin_state(pin_state)
);

// File: tb/tb_irq_pin_cond.sv
`timescale 1ns/1ps
module tb_irq_pin_cond;
  logic       clk = 1'b0;
  logic       rst;
  logic       ev_valid;
  logic [2:0] ev_idx;
  logic       ev_level;
  logic [3:0] clr_mask;
  logic [3:0] pend_vec;
  logic       irq_req, halt, hreset_pulse;
  logic [5:0] pin_state;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [5:0] m_st;
  logic [3:0] m_pend;
  logic       m_halt, m_hr;

  always #2 clk = ~clk;

  irq_pin_cond dut (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_idx(ev_idx),
    .ev_level(ev_level), .clr_mask(clr_mask), .pend_vec(pend_vec),
    .irq_req(irq_req), .halt(halt), .hreset_pulse(hreset_pulse),
    .pin_state(pin_state)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2/R3/R4/R6/R12 pend_vec", {4'd0, pend_vec}, {4'd0, m_pend});
    chk("R7 irq_req", {7'd0, irq_req}, {7'd0, |m_pend});
    chk("R5 halt", {7'd0, halt}, {7'd0, m_halt});
    chk("R11 hreset_pulse", {7'd0, hreset_pulse}, {7'd0, m_hr});
    chk("R1/R8/R9 pin_state", {2'd0, pin_state}, {2'd0, m_st});
  endtask

  // drive at negedge, model the next edge, compare at the following negedge
  task automatic apply(logic v, logic [2:0] idx, logic lvl, logic [3:0] clr);
    logic hit;
    ev_valid = v; ev_idx = idx; ev_level = lvl; clr_mask = clr;
    hit  = v && idx < 3'd6 && lvl != m_st[idx];
    m_hr = hit && idx == 3'd4 && lvl;
    if (hit) begin
      case (idx)
        3'd0: m_pend[0] = lvl;
        3'd1: m_pend[1] = lvl;
        3'd3: m_halt    = lvl;
        3'd5: m_pend[3] = lvl;
        default: ;
      endcase
    end
    if (hit && idx == 3'd2 && !lvl) m_pend[2] = 1'b1;
    else if (clr[2])                m_pend[2] = 1'b0;
    if (hit) m_st[idx] = lvl;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; ev_valid = 0; ev_idx = 0; ev_level = 0; clr_mask = 0;
    m_st = 0; m_pend = 0; m_halt = 0; m_hr = 0;
    repeat (3) @(negedge clk);
    // R10: assert reset state after junk inputs
    ev_valid = 1; ev_idx = 3'd3; ev_level = 1;
    @(negedge clk);
    check_all();
    rst = 1'b0;
    apply(0, 0, 0, 0);

    // R2 external and management level follow
    apply(1, 0, 1, 0);
    apply(1, 1, 1, 0);
    // R1 repeated same level is silent
    apply(1, 0, 1, 0);
    // R12 clears on non-sticky bits ignored
    apply(0, 0, 0, 4'b1011);
    apply(1, 0, 0, 0);
    apply(1, 1, 0, 0);
    // R3 rising on machine check does nothing, falling sets
    apply(1, 2, 1, 0);
    apply(1, 2, 0, 0);
    // R4 sticky until clear
    apply(0, 0, 0, 0);
    apply(0, 0, 0, 4'b0100);
    // R4 falling edge wins over clear in same cycle
    apply(1, 2, 1, 0);
    apply(1, 2, 0, 4'b0100);
    apply(0, 0, 0, 4'b0100);
    // R5 halt follows checkstop
    apply(1, 3, 1, 0);
    apply(1, 3, 1, 0);
    apply(1, 3, 0, 0);
    // R11 hard reset pulse one cycle only on rise
    apply(1, 4, 1, 0);
    apply(0, 0, 0, 0);
    apply(1, 4, 0, 0);
    // R6 soft reset mirrored
    apply(1, 5, 1, 0);
    apply(1, 5, 0, 0);
    // R8 unknown indices ignored
    apply(1, 6, 1, 0);
    apply(1, 7, 1, 0);
    // R9 random streams against the model
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] c;
      c = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
      apply(($urandom % 4) != 0, 3'($urandom), 1'($urandom), c);
    end
    // R10 reset from busy state
    apply(1, 3, 1, 0);
    rst = 1'b1; ev_valid = 0;
    m_st = 0; m_pend = 0; m_halt = 0; m_hr = 0;
    @(negedge clk);
    check_all();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule